// File: doc/BRIEF.md
# Processor Control Register Bank

This block keeps the control and status registers of a processor core. A 5-bit index selects one of 32 slots for the single write port and, independently, for the single read port. Every slot that accepts writes applies its own rule to the incoming word: bit clearing, a field mask, a sign fold, or field capture. A privileged write flag widens what may be changed. Several slots are fixed identification constants, and unused slots read as zero.

The read port is combinational from the stored state. A value written at a clock edge is therefore visible on the read port in the following cycle. The cache-control fields are also driven out on dedicated outputs, so the cache logic can act on them.

Slot map (the index a register answers to is part of its contract): 0 irq saved PC, 1 irq saved status, 2 fatal saved PC, 3 fatal saved status, 4 cause, 5 status word, 6 processor ID, 7 task control, 24 cache control, 25 trap address, 29 plain scratch, 30 fixed value, 31 absolute-value scratch.

Top module: `sysreg_file`

## Requirements
- R1: A write to slot 0, 2 or 25 stores the word with bit 0 forced to 0.
- R2: A write to slot 1 or 3 stores the word ANDed with 0x000FF3FF.
- R3: The status word (slot 5) keeps bits 19:12 and 9:0 of a write, and reads bits 31:20 and 11:10 as zero. Its reset value is 0x00008000, which is the NMI-pending flag at bit 15.
- R4: The cause register (slot 4) resets to 0x0000FFF0. A write to it takes effect only when `wr_dbg` is 1; otherwise the write leaves it unchanged.
- R5: Slot 6 always reads 0x00005346, slot 7 reads 0x000000E0, and slot 30 reads 0x00000004. Writes to these slots have no effect.
- R6: Slot 31 stores the word unchanged when `wr_dbg` is 1 or bit 31 of the word is 0. Otherwise it stores the two's-complement negation (0x80000000 stays 0x80000000).
- R7: Slot 29 stores any written word unchanged.
- R8: A write to slot 24 captures entry number = bits 31:20, entry count = bits 19:8, spill base = bits 31:8, restore = bit 5, dump = bit 4, enable = bit 1 and clear = bit 0 on the `cc_*` outputs. Reading slot 24 returns only the enable flag, at bit 1.
- R9: Slots 8 to 23 and 26 to 28 read as zero, and writes to them change no slot.
- R10: The read port is combinational in `rd_idx`. Data written at an edge is visible on the next cycle.
- R11: After reset, every slot not named in R3, R4 or R5 reads zero, and all `cc_*` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write slot index |
| wr_data | input | 32 | Write word |
| wr_dbg | input | 1 | Privileged (debug) write flag |
| rd_idx | input | 5 | Read slot index |
| rd_data | output | 32 | Read word |
| cc_entry_num | output | 12 | Cache clear entry number |
| cc_entry_cnt | output | 12 | Cache clear entry count |
| cc_spill_base | output | 24 | Cache spill base address |
| cc_restore | output | 1 | Cache restore request flag |
| cc_dump | output | 1 | Cache dump request flag |
| cc_enable | output | 1 | Cache enable |
| cc_clear | output | 1 | Cache clear request flag |

## Verification
The hardest case is a write that must leave state untouched. Examples are a non-privileged cause write, a write to a constant slot, and a write to an unused index. Neither kind of write shows at its own slot unless the old contents are known and differ from the written word. The bench therefore first loads every slot with a distinct privileged pattern. It then sweeps all 32 indices with several data words in both privilege modes. After each write it reads back the written slot, and after each pass it rereads all 32 slots, so that any stray update to a neighbouring slot is caught.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 5;
    localparam int NSLOT   = 1 << IDX_W;
    localparam int CC_NUM_W   = 12;
    localparam int CC_CNT_W   = 12;
    localparam int CC_SPILL_W = 24;
    localparam int CC_NUM_LSB   = 20;
    localparam int CC_CNT_LSB   = 8;
    localparam int CC_SPILL_LSB = 8;
    localparam int CC_RST_BIT   = 5;
    localparam int CC_DUMP_BIT  = 4;
    localparam int CC_EN_BIT    = 1;
    localparam int CC_CLR_BIT   = 0;

    localparam logic [IDX_W-1:0] IX_IRQ_PC    = 5'd0;
    localparam logic [IDX_W-1:0] IX_IRQ_SR    = 5'd1;
    localparam logic [IDX_W-1:0] IX_FATAL_PC  = 5'd2;
    localparam logic [IDX_W-1:0] IX_FATAL_SR  = 5'd3;
    localparam logic [IDX_W-1:0] IX_CAUSE     = 5'd4;
    localparam logic [IDX_W-1:0] IX_STATUS    = 5'd5;
    localparam logic [IDX_W-1:0] IX_PROC_ID   = 5'd6;
    localparam logic [IDX_W-1:0] IX_TASKCTL   = 5'd7;
    localparam logic [IDX_W-1:0] IX_CACHECTL  = 5'd24;
    localparam logic [IDX_W-1:0] IX_TRAPADDR  = 5'd25;
    localparam logic [IDX_W-1:0] IX_SCRATCH   = 5'd29;
    localparam logic [IDX_W-1:0] IX_FIXED     = 5'd30;
    localparam logic [IDX_W-1:0] IX_ABS       = 5'd31;

    localparam logic [XLEN-1:0] STATUS_MASK  = 32'h000F_F3FF;
    localparam logic [XLEN-1:0] PC_MASK      = 32'hFFFF_FFFE;
    localparam logic [XLEN-1:0] PROC_ID_VAL  = 32'h0000_5346;
    localparam logic [XLEN-1:0] TASKCTL_VAL  = 32'h0000_00E0;
    localparam logic [XLEN-1:0] FIXED_VAL    = 32'h0000_0004;
    localparam logic [XLEN-1:0] CAUSE_RST    = 32'h0000_FFF0;
    localparam logic [XLEN-1:0] STATUS_RST   = 32'h0000_8000;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_PCMASK,
        WK_SRMASK,
        WK_PLAIN,
        WK_DEBUG,
        WK_ABS,
        WK_CACHE
    } wkind_e;

    typedef struct packed {
        logic [XLEN-1:0]       irq_pc;
        logic [XLEN-1:0]       irq_sr;
        logic [XLEN-1:0]       fatal_pc;
        logic [XLEN-1:0]       fatal_sr;
        logic [XLEN-1:0]       cause;
        logic [XLEN-1:0]       status;
        logic [XLEN-1:0]       trapaddr;
        logic [XLEN-1:0]       scratch;
        logic [XLEN-1:0]       absreg;
        logic [CC_NUM_W-1:0]   cc_num;
        logic [CC_CNT_W-1:0]   cc_cnt;
        logic [CC_SPILL_W-1:0] cc_spill;
        logic                  cc_rst;
        logic                  cc_dump;
        logic                  cc_en;
        logic                  cc_clr;
    } sr_state_t;

    localparam sr_state_t SR_RESET = '{
        irq_pc:   '0,
        irq_sr:   '0,
        fatal_pc: '0,
        fatal_sr: '0,
        cause:    CAUSE_RST,
        status:   STATUS_RST,
        trapaddr: '0,
        scratch:  '0,
        absreg:   '0,
        cc_num:   '0,
        cc_cnt:   '0,
        cc_spill: '0,
        cc_rst:   1'b0,
        cc_dump:  1'b0,
        cc_en:    1'b0,
        cc_clr:   1'b0
    };

endpackage

// File: rtl/sysreg_wr_xform.sv
module sysreg_wr_xform
    import sysreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  data,
    input  logic             dbg,
    output wkind_e           kind,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] negated;

    assign negated = (~data) + {{(XLEN-1){1'b0}}, 1'b1};

    always_comb begin
        kind = WK_NONE;
        case (idx)
            IX_IRQ_PC, IX_FATAL_PC, IX_TRAPADDR: kind = WK_PCMASK;
            IX_IRQ_SR, IX_FATAL_SR, IX_STATUS:   kind = WK_SRMASK;
            IX_CAUSE:                            kind = dbg ? WK_DEBUG : WK_NONE;
            IX_SCRATCH:                          kind = WK_PLAIN;
            IX_ABS:                              kind = WK_ABS;
            IX_CACHECTL:                         kind = WK_CACHE;
            default:                             kind = WK_NONE;
        endcase
    end

    always_comb begin
        case (kind)
            WK_PCMASK: value = data & PC_MASK;
            WK_SRMASK: value = data & STATUS_MASK;
            WK_ABS:    value = (dbg || !data[XLEN-1]) ? data : negated;
            default:   value = data;
        endcase
    end
endmodule

// File: rtl/sysreg_rd_mux.sv
module sysreg_rd_mux
    import sysreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  sr_state_t        st,
    output logic [XLEN-1:0]  data
);
    logic [XLEN-1:0] cc_view;

    always_comb begin
        cc_view = '0;
        cc_view[CC_EN_BIT] = st.cc_en;
    end

    always_comb begin
        case (idx)
            IX_IRQ_PC:   data = st.irq_pc;
            IX_IRQ_SR:   data = st.irq_sr;
            IX_FATAL_PC: data = st.fatal_pc;
            IX_FATAL_SR: data = st.fatal_sr;
            IX_CAUSE:    data = st.cause;
            IX_STATUS:   data = st.status & STATUS_MASK;
            IX_PROC_ID:  data = PROC_ID_VAL;
            IX_TASKCTL:  data = TASKCTL_VAL;
            IX_CACHECTL: data = cc_view;
            IX_TRAPADDR: data = st.trapaddr;
            IX_SCRATCH:  data = st.scratch;
            IX_FIXED:    data = FIXED_VAL;
            IX_ABS:      data = st.absreg;
            default:     data = '0;
        endcase
    end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
    import sysreg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [XLEN-1:0]       wr_data,
    input  logic                  wr_dbg,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [XLEN-1:0]       rd_data,
    output logic [CC_NUM_W-1:0]   cc_entry_num,
    output logic [CC_CNT_W-1:0]   cc_entry_cnt,
    output logic [CC_SPILL_W-1:0] cc_spill_base,
    output logic                  cc_restore,
    output logic                  cc_dump,
    output logic                  cc_enable,
    output logic                  cc_clear
);
    sr_state_t       st_d, st_q;
    wkind_e          kind;
    logic [XLEN-1:0] wval;

    sysreg_wr_xform u_xform (
        .idx   (wr_idx),
        .data  (wr_data),
        .dbg   (wr_dbg),
        .kind  (kind),
        .value (wval)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && kind != WK_NONE) begin
            case (wr_idx)
                IX_IRQ_PC:   st_d.irq_pc   = wval;
                IX_IRQ_SR:   st_d.irq_sr   = wval;
                IX_FATAL_PC: st_d.fatal_pc = wval;
                IX_FATAL_SR: st_d.fatal_sr = wval;
                IX_CAUSE:    st_d.cause    = wval;
                IX_STATUS:   st_d.status   = wval;
                IX_TRAPADDR: st_d.trapaddr = wval;
                IX_SCRATCH:  st_d.scratch  = wval;
                IX_ABS:      st_d.absreg   = wval;
                IX_CACHECTL: begin
                    st_d.cc_num   = wval[CC_NUM_LSB +: CC_NUM_W];
                    st_d.cc_cnt   = wval[CC_CNT_LSB +: CC_CNT_W];
                    st_d.cc_spill = wval[CC_SPILL_LSB +: CC_SPILL_W];
                    st_d.cc_rst   = wval[CC_RST_BIT];
                    st_d.cc_dump  = wval[CC_DUMP_BIT];
                    st_d.cc_en    = wval[CC_EN_BIT];
                    st_d.cc_clr   = wval[CC_CLR_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SR_RESET;
        else        st_q <= st_d;
    end

    sysreg_rd_mux u_rd (
        .idx  (rd_idx),
        .st   (st_q),
        .data (rd_data)
    );

    assign cc_entry_num  = st_q.cc_num;
    assign cc_entry_cnt  = st_q.cc_cnt;
    assign cc_spill_base = st_q.cc_spill;
    assign cc_restore    = st_q.cc_rst;
    assign cc_dump       = st_q.cc_dump;
    assign cc_enable     = st_q.cc_en;
    assign cc_clear      = st_q.cc_clr;
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk
    import sysreg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic             wr_dbg,
    input logic [IDX_W-1:0] rd_idx,
    input logic [XLEN-1:0]  rd_data,
    input logic             cc_enable
);
    p_pc_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IX_IRQ_PC || wr_idx == IX_FATAL_PC || wr_idx == IX_TRAPADDR))
        |=> (rd_idx != $past(wr_idx)) || (rd_data == ($past(wr_data) & PC_MASK)));

    p_sr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == IX_IRQ_SR || wr_idx == IX_FATAL_SR))
        |=> (rd_idx != $past(wr_idx)) || (rd_data == ($past(wr_data) & STATUS_MASK)));

    p_status_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_STATUS) |-> (rd_data[31:20] == 12'h0 && rd_data[11:10] == 2'b00));

    p_cause_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_CAUSE && !wr_dbg && rd_idx == IX_CAUSE)
        |=> (rd_idx != IX_CAUSE) || $stable(rd_data));

    p_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_PROC_ID) |-> (rd_data == PROC_ID_VAL));

    p_abs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IX_ABS && !wr_dbg && wr_data[31])
        |=> (rd_idx != IX_ABS) || (rd_data == (~$past(wr_data) + 32'd1)));

    p_cache_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IX_CACHECTL) |-> (rd_data == {30'b0, cc_enable, 1'b0}));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= 5'd8 && rd_idx <= 5'd23) |-> (rd_data == '0));
endmodule

bind sysreg_file sysreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_dbg    (wr_dbg),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .cc_enable (cc_enable)
);

// File: tb/sim_sysreg_file.sv
module sim_sysreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_dbg = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [11:0] cc_entry_num, cc_entry_cnt;
    logic [23:0] cc_spill_base;
    logic        cc_restore, cc_dump, cc_enable, cc_clear;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m [32];
    logic [11:0] e_num, e_cnt;
    logic [23:0] e_spill;
    logic [3:0]  e_flags;

    always #2.5 clk = ~clk;

    sysreg_file u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_dbg(wr_dbg), .rd_idx(rd_idx), .rd_data(rd_data),
        .cc_entry_num(cc_entry_num), .cc_entry_cnt(cc_entry_cnt),
        .cc_spill_base(cc_spill_base), .cc_restore(cc_restore),
        .cc_dump(cc_dump), .cc_enable(cc_enable), .cc_clear(cc_clear)
    );

    function automatic string req_of(input int i);
        case (i)
            0, 2, 25: return "R1";
            1, 3:     return "R2";
            5:        return "R3";
            4:        return "R4";
            6, 7, 30: return "R5";
            31:       return "R6";
            29:       return "R7";
            24:       return "R8";
            default:  return "R9";
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input int i);
        case (i)
            6:       return 32'h0000_5346;
            7:       return 32'h0000_00E0;
            30:      return 32'h0000_0004;
            default: return m[i];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic model_write(input int i, input logic [31:0] d, input logic dbg);
        case (i)
            0, 2, 25: m[i] = {d[31:1], 1'b0};
            1, 3, 5:  m[i] = d & 32'h000F_F3FF;
            4:        if (dbg) m[i] = d;
            29:       m[i] = d;
            31:       m[i] = (dbg || !d[31]) ? d : (32'd0 - d);
            24: begin
                e_num = d[31:20]; e_cnt = d[19:8]; e_spill = d[31:8];
                e_flags = {d[5], d[4], d[1], d[0]};
                m[i] = {30'd0, d[1], 1'b0};
            end
            default: ;
        endcase
    endtask

    task automatic do_write(input int i, input logic [31:0] d, input logic dbg);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(i); wr_data = d; wr_dbg = dbg;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(i, d, dbg);
    endtask

    task automatic read_chk(input int i, input string req);
        rd_idx = 5'(i);
        #0.5;
        check(req, rd_data, exp_read(i));
    endtask

    task automatic check_cc(input string req);
        check(req, {20'd0, cc_entry_num}, {20'd0, e_num});
        check(req, {20'd0, cc_entry_cnt}, {20'd0, e_cnt});
        check(req, {8'd0, cc_spill_base}, {8'd0, e_spill});
        check(req, {28'd0, cc_restore, cc_dump, cc_enable, cc_clear}, {28'd0, e_flags});
    endtask

    task automatic sweep_all(input string tag);
        for (int i = 0; i < 32; i++) read_chk(i, tag);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] pats [8];
        pats = '{32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5B, 32'h8000_0000,
                 32'h7FFF_FFFF, 32'h1234_5679, 32'hFFFF_FFFE, 32'h0000_0000};
        for (int i = 0; i < 32; i++) m[i] = '0;
        m[4] = 32'h0000_FFF0;
        m[5] = 32'h0000_8000;
        e_num = '0; e_cnt = '0; e_spill = '0; e_flags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R3 / R4 / R5: reset contents of every slot and cache outputs
        sweep_all("R11");
        check_cc("R11");

        // R10: combinational read, next-cycle visibility on a scratch slot
        do_write(29, 32'hDEAD_BEEF, 1'b0);
        read_chk(29, "R10");
        rd_idx = 5'd6; #0.5;
        check("R10", rd_data, 32'h0000_5346);

        // preload every slot with privileged writes so ignored writes are visible
        for (int i = 0; i < 32; i++) do_write(i, 32'hC3C3_0F0F ^ 32'(i), 1'b1);
        sweep_all("R9");

        for (int p = 0; p < 8; p++) begin
            for (int dbg = 0; dbg < 2; dbg++) begin
                for (int i = 0; i < 32; i++) begin
                    do_write(i, pats[p] ^ (32'(i) << 8), dbg[0]);
                    read_chk(i, req_of(i));
                    if (i == 24) check_cc("R8");
                end
                sweep_all("R9");
            end
        end

        // R6: most negative value keeps its pattern
        do_write(31, 32'h8000_0000, 1'b0);
        read_chk(31, "R6");
        // R4: non-debug cause write after known debug value
        do_write(4, 32'h1111_2222, 1'b1);
        do_write(4, 32'h3333_4444, 1'b0);
        read_chk(4, "R4");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule